// File: doc/BRIEF.md
# Wake-up External Interrupt Demultiplexer

This block watches 28 asynchronous wake-up lines and turns activity on them into four parent interrupt requests. Every line passes through a two-stage synchroniser and is then judged against a 4-bit trigger code. The code selects low level, high level, falling edge, rising edge or both edges. A qualifying event sets that line's pending bit, and the bit holds until software clears it.

Each parent request covers a fixed, contiguous run of lines. The first run is four lines wide and the other three are eight lines wide. A parent request is high while any line in its run is both pending and unmasked. Software reaches the block through a simple register port with four addresses: two trigger-configuration words, one mask word and one pending word that is cleared by writing ones.

Trigger fields are shared: the two lines of each adjacent pair (2k, 2k+1) use the same 4-bit code. Lines 0 to 15 are configured in the first word and lines 16 to 27 in the second.

Top module: `wake_irq_demux`

## Requirements
- R1: After reset every line is masked, no line is pending, all four parent requests are low, and both configuration words read 0xFFFFFFFF.
- R2: The register address map is as follows. Address 0 is the configuration word for lines 0–15 and address 1 the configuration word for lines 16–27. Address 2 is the mask word, where bit i = 1 masks line i. Address 3 is the pending word. Reads return the stored value, and mask and pending bits 31:28 read as 0 whatever is written there.
- R3: Line i takes its trigger code from word i/16, bits [4·((i mod 16)/2) +: 4]. Lines 2k and 2k+1 therefore share one field.
- R4: Code 0 (low level) and code 1 (high level) set the pending bit on every cycle the synchronised line is at that level. This holds even while the bit is being cleared.
- R5: Code 2 sets the pending bit on a falling edge, code 4 on a rising edge and code 6 on either edge. The opposite edge has no effect in codes 2 and 4.
- R6: Every other code (3, 5, 7 to 15) never sets a pending bit.
- R7: Pending bits latch whether or not the line is masked. A parent request depends only on pending AND NOT mask, so unmasking a line that is already pending raises its parent request straight after the mask write.
- R8: Parent request 0 covers lines 0–3, request 1 lines 4–11, request 2 lines 12–19 and request 3 lines 20–27.
- R9: Writing a 1 to a pending bit clears it and writing a 0 leaves it unchanged. When a clear and a new event on the same line fall in the same cycle, the bit stays set.
- R10: A change on an input line sets its pending bit on the third rising clock edge after the change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_in | input | 28 | Asynchronous wake-up lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq_out | output | 4 | Parent interrupt requests |

## Verification
A line change is driven at a falling clock edge. The pending bit is due after the third rising edge that follows, so the bench checks it is still clear after two edges and set after three. Register writes and pending clears act on the single rising edge inside the write strobe. Parent requests are a combinational function of the registered mask and pending bits, so every result is read at the falling edge after the edge that should produce it. The bench also lines a clear up with the exact edge at which an edge event lands, to cover the case where both act on the same bit in one cycle.

// File: rtl/wk_pkg.sv
package wk_pkg;
    localparam int WK_FIELD_W = 4;
    localparam int WK_PAIR    = 2;

    typedef enum logic [WK_FIELD_W-1:0] {
        TRG_LOW  = 4'd0,
        TRG_HIGH = 4'd1,
        TRG_FALL = 4'd2,
        TRG_RISE = 4'd4,
        TRG_BOTH = 4'd6
    } trig_e;
endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
    parameter int W = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = raw;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur  = st_q.s2;
    assign prev = st_q.s3;
endmodule

// File: rtl/wk_detect.sv
module wk_detect import wk_pkg::*; #(
    parameter int NUM_IN    = 28,
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 2
) (
    input  logic [NUM_WORDS*WORD_W-1:0] cfg_flat,
    input  logic [NUM_IN-1:0]           cur,
    input  logic [NUM_IN-1:0]           prev,
    output logic [NUM_IN-1:0]           evt
);
    localparam int FIELDS_PER_WORD = WORD_W / WK_FIELD_W;
    localparam int IN_PER_WORD     = FIELDS_PER_WORD * WK_PAIR;

    // Fields beyond the last line are storage only.
    logic unused_cfg;
    assign unused_cfg = ^cfg_flat;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_line
        localparam int BASE = (i / IN_PER_WORD) * WORD_W
                            + ((i % IN_PER_WORD) / WK_PAIR) * WK_FIELD_W;
        logic [WK_FIELD_W-1:0] code;
        assign code = cfg_flat[BASE +: WK_FIELD_W];

        always_comb begin
            case (code)
                TRG_LOW:  evt[i] = ~cur[i];
                TRG_HIGH: evt[i] =  cur[i];
                TRG_FALL: evt[i] =  prev[i] & ~cur[i];
                TRG_RISE: evt[i] = ~prev[i] &  cur[i];
                TRG_BOTH: evt[i] =  prev[i] ^  cur[i];
                default:  evt[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/wk_combine.sv
module wk_combine #(
    parameter int FIRST_SPAN = 4,
    parameter int SPAN       = 8,
    parameter int NUM_OUT    = 4,
    parameter int NUM_IN     = FIRST_SPAN + (NUM_OUT - 1) * SPAN
) (
    input  logic [NUM_IN-1:0]  pend,
    input  logic [NUM_IN-1:0]  mask,
    output logic [NUM_OUT-1:0] irq
);
    logic [NUM_IN-1:0] live;
    assign live = pend & ~mask;

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        localparam int LO = (o == 0) ? 0 : FIRST_SPAN + (o - 1) * SPAN;
        localparam int HI = (o == 0) ? FIRST_SPAN - 1 : LO + SPAN - 1;
        assign irq[o] = |live[HI:LO];
    end
endmodule

// File: rtl/wake_irq_demux.sv
module wake_irq_demux import wk_pkg::*; #(
    parameter int FIRST_SPAN   = 4,
    parameter int SPAN         = 8,
    parameter int NUM_OUT      = 4,
    parameter int WORD_W       = 32,
    localparam int NUM_IN      = FIRST_SPAN + (NUM_OUT - 1) * SPAN,
    localparam int IN_PER_WORD = (WORD_W / WK_FIELD_W) * WK_PAIR,
    localparam int NUM_WORDS   = (NUM_IN + IN_PER_WORD - 1) / IN_PER_WORD,
    localparam int MASK_ADDR   = NUM_WORDS,
    localparam int PEND_ADDR   = NUM_WORDS + 1,
    localparam int AW          = $clog2(NUM_WORDS + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IN-1:0]  wake_in,
    input  logic               reg_wr,
    input  logic [AW-1:0]      reg_addr,
    input  logic [WORD_W-1:0]  reg_wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    output logic [NUM_OUT-1:0] irq_out
);
    typedef struct packed {
        logic [NUM_WORDS-1:0][WORD_W-1:0] cfg;
        logic [NUM_IN-1:0]                mask;
        logic [NUM_IN-1:0]                pend;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_IN-1:0] line_cur, line_prev, evt;
    logic [NUM_IN-1:0] mask_q, pend_q;

    assign mask_q = st_q.mask;
    assign pend_q = st_q.pend;

    wk_sync #(.W(NUM_IN)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (wake_in),
        .cur  (line_cur),
        .prev (line_prev)
    );

    wk_detect #(.NUM_IN(NUM_IN), .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_detect (
        .cfg_flat(st_q.cfg),
        .cur     (line_cur),
        .prev    (line_prev),
        .evt     (evt)
    );

    wk_combine #(.FIRST_SPAN(FIRST_SPAN), .SPAN(SPAN), .NUM_OUT(NUM_OUT),
                 .NUM_IN(NUM_IN)) u_combine (
        .pend(pend_q),
        .mask(mask_q),
        .irq (irq_out)
    );

    // Next-state computation for the register file and pending bits.
    always_comb begin
        logic [NUM_IN-1:0] clr;
        st_d = st_q;
        clr  = '0;
        if (reg_wr) begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                if (reg_addr == AW'(w)) st_d.cfg[w] = reg_wdata;
            end
            if (reg_addr == AW'(MASK_ADDR)) st_d.mask = reg_wdata[NUM_IN-1:0];
            if (reg_addr == AW'(PEND_ADDR)) clr = reg_wdata[NUM_IN-1:0];
        end
        // A new event wins over a clear of the same bit.
        st_d.pend = (st_q.pend & ~clr) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg  <= '1;
            st_q.mask <= '1;
            st_q.pend <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (reg_addr == AW'(w)) reg_rdata = st_q.cfg[w];
        end
        if (reg_addr == AW'(MASK_ADDR)) reg_rdata[NUM_IN-1:0] = st_q.mask;
        if (reg_addr == AW'(PEND_ADDR)) reg_rdata[NUM_IN-1:0] = st_q.pend;
    end
endmodule

// File: rtl/wk_demux_chk.sv
module wk_demux_chk #(
    parameter int NUM_IN     = 28,
    parameter int NUM_OUT    = 4,
    parameter int FIRST_SPAN = 4,
    parameter int SPAN       = 8,
    parameter int AW         = 2,
    parameter int WORD_W     = 32,
    parameter int MASK_ADDR  = 2,
    parameter int PEND_ADDR  = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [AW-1:0]      reg_addr,
    input logic [WORD_W-1:0]  reg_wdata,
    input logic [NUM_OUT-1:0] irq_out,
    input logic [NUM_IN-1:0]  mask_q,
    input logic [NUM_IN-1:0]  pend_q
);
    logic unused_wdata;
    assign unused_wdata = ^reg_wdata;

    // R1: first cycle out of reset is masked and idle
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pend_q == '0 && mask_q == '1));

    // R7: with every line masked no parent request can be high
    a_r7_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> (irq_out == '0));

    // R2: a mask write is stored on the following edge
    a_r2_mask_store: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == AW'(MASK_ADDR)) |=> (mask_q == $past(reg_wdata[NUM_IN-1:0])));

    for (genvar i = 0; i < NUM_IN; i++) begin : g_bit
        // R9: a pending bit only drops after a write of 1 to it
        a_r9_drop_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pend_q[i]) |-> ($past(reg_wr) && $past(reg_addr) == AW'(PEND_ADDR)
                                  && $past(reg_wdata[i])));
    end

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        localparam int LO = (o == 0) ? 0 : FIRST_SPAN + (o - 1) * SPAN;
        localparam int HI = (o == 0) ? FIRST_SPAN - 1 : LO + SPAN - 1;
        // R8: a parent request needs a pending line inside its own run
        a_r8_out_in_range: assert property (@(posedge clk) disable iff (!rst_n)
            irq_out[o] |-> (|pend_q[HI:LO]));
    end
endmodule

bind wake_irq_demux wk_demux_chk #(
    .NUM_IN    (NUM_IN),
    .NUM_OUT   (NUM_OUT),
    .FIRST_SPAN(FIRST_SPAN),
    .SPAN      (SPAN),
    .AW        (AW),
    .WORD_W    (WORD_W),
    .MASK_ADDR (MASK_ADDR),
    .PEND_ADDR (PEND_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .irq_out  (irq_out),
    .mask_q   (mask_q),
    .pend_q   (pend_q)
);

// File: tb/wake_irq_demux_test.sv
`timescale 1ns/1ps
module wake_irq_demux_test;
    localparam int NIN = 28;
    localparam logic [31:0] ALL_MASK = 32'h0FFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NIN-1:0] pins = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  irq_out;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    wake_irq_demux uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wake_in  (pins),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .irq_out  (irq_out)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic set_pins(input logic [NIN-1:0] sel, input logic v);
        @(negedge clk);
        for (int i = 0; i < NIN; i++) if (sel[i]) pins[i] = v;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [3:0] parent_of(input int i);
        if (i < 4) return 4'b0001;
        return 4'b0001 << ((i - 4) / 8 + 1);
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); check("R1 cfg word 0 reset", v, 32'hFFFF_FFFF);
        rd(2'd1, v); check("R1 cfg word 1 reset", v, 32'hFFFF_FFFF);
        rd(2'd2, v); check("R1 mask reset", v, ALL_MASK);
        rd(2'd3, v); check("R1 pending reset", v, 32'h0);
        check("R1 parents low", {28'h0, irq_out}, 32'h0);
    endtask

    task automatic t_rise();
        logic [31:0] v;
        wr(2'd0, 32'hFFFF_FF4F);
        wr(2'd2, 32'h0);
        set_pins(28'h4, 1'b1);
        repeat (2) @(negedge clk);
        rd(2'd3, v); check("R10 not yet pending after two edges", v, 32'h0);
        @(negedge clk);
        rd(2'd3, v); check("R10 R5 rising sets line 2", v, 32'h4);
        check("R8 line 2 on parent 0", {28'h0, irq_out}, 32'h1);
        set_pins(28'h4, 1'b0); settle();
        rd(2'd3, v); check("R5 falling ignored in rising code", v, 32'h4);
        wr(2'd3, 32'h4);
        rd(2'd3, v); check("R9 write one clears", v, 32'h0);
        set_pins(28'h8, 1'b1); settle();
        rd(2'd3, v); check("R3 line 3 shares field of line 2", v, 32'h8);
        wr(2'd3, 32'h8);
        set_pins(28'h8, 1'b0); settle();
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd2, ALL_MASK);
    endtask

    task automatic t_fall_both();
        logic [31:0] v;
        wr(2'd0, 32'hFFFF_F2FF);
        wr(2'd2, 32'h0);
        set_pins(28'h20, 1'b1); settle();
        rd(2'd3, v); check("R5 rising ignored in falling code", v, 32'h0);
        set_pins(28'h20, 1'b0); settle();
        rd(2'd3, v); check("R5 falling sets line 5", v, 32'h20);
        check("R8 line 5 on parent 1", {28'h0, irq_out}, 32'h2);
        wr(2'd3, 32'h20);
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd1, 32'hFFFF_FFF6);
        set_pins(28'h2_0000, 1'b1); settle();
        rd(2'd3, v); check("R5 both-edge rise line 17", v, 32'h2_0000);
        check("R8 line 17 on parent 2", {28'h0, irq_out}, 32'h4);
        wr(2'd3, 32'h2_0000);
        set_pins(28'h2_0000, 1'b0); settle();
        rd(2'd3, v); check("R5 both-edge fall line 17", v, 32'h2_0000);
        wr(2'd3, 32'h2_0000);
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd2, ALL_MASK);
    endtask

    task automatic t_level();
        logic [31:0] v;
        wr(2'd1, 32'hFFFF_F1FF);
        wr(2'd2, 32'h0);
        set_pins(28'h10_0000, 1'b1); settle();
        rd(2'd3, v); check("R4 high level sets line 20", v, 32'h10_0000);
        check("R8 line 20 on parent 3", {28'h0, irq_out}, 32'h8);
        wr(2'd3, 32'h10_0000);
        rd(2'd3, v); check("R4 active level survives clear", v, 32'h10_0000);
        set_pins(28'h10_0000, 1'b0); settle();
        wr(2'd3, 32'h10_0000);
        rd(2'd3, v); check("R4 clear after level gone", v, 32'h0);
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd0, 32'hFFFF_FFF0);
        @(negedge clk);
        rd(2'd3, v); check("R4 R3 low level sets lines 0 and 1", v, 32'h3);
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd3, 32'h3);
        settle();
        rd(2'd3, v); check("R4 no events once code removed", v, 32'h0);
        wr(2'd2, ALL_MASK);
    endtask

    task automatic t_undefined();
        logic [31:0] v;
        wr(2'd1, 32'hFFFF_873F);
        wr(2'd2, 32'h0);
        set_pins(28'hFC_0000, 1'b1); settle();
        rd(2'd3, v); check("R6 codes 3 7 8 ignore rise and high", v, 32'h0);
        set_pins(28'hFC_0000, 1'b0); settle();
        rd(2'd3, v); check("R6 codes 3 7 8 ignore fall and low", v, 32'h0);
        check("R6 parents stay low", {28'h0, irq_out}, 32'h0);
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd2, ALL_MASK);
    endtask

    task automatic t_mask_ranges();
        logic [31:0] v;
        wr(2'd0, 32'h4444_4444);
        wr(2'd1, 32'h4444_4444);
        rd(2'd1, v); check("R2 cfg word 1 readback", v, 32'h4444_4444);
        for (int i = 0; i < NIN; i++) begin
            logic [31:0] bit_i;
            bit_i = 32'h1 << i;
            set_pins(bit_i[NIN-1:0], 1'b1); settle();
            rd(2'd3, v); check($sformatf("R7 line %0d pends while masked", i), v, bit_i);
            check($sformatf("R7 line %0d masked parent low", i), {28'h0, irq_out}, 32'h0);
            wr(2'd2, ALL_MASK & ~bit_i);
            check($sformatf("R8 line %0d unmask raises parent", i),
                  {28'h0, irq_out}, {28'h0, parent_of(i)});
            wr(2'd2, ALL_MASK);
            wr(2'd3, bit_i);
            rd(2'd3, v); check($sformatf("R9 line %0d cleared", i), v, 32'h0);
            set_pins(bit_i[NIN-1:0], 1'b0); settle();
        end
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        set_pins(28'h200_0040, 1'b1); settle();
        rd(2'd3, v); check("R9 two lines pending", v, 32'h0200_0040);
        wr(2'd3, 32'h0);
        rd(2'd3, v); check("R9 zero write keeps bits", v, 32'h0200_0040);
        wr(2'd3, 32'h40);
        rd(2'd3, v); check("R9 clears only written bit", v, 32'h0200_0000);
        wr(2'd3, 32'h0200_0000);
        set_pins(28'h200_0040, 1'b0); settle();
        set_pins(28'h200, 1'b1);
        @(negedge clk);
        wr(2'd3, 32'h200);
        rd(2'd3, v); check("R9 same-cycle event beats clear", v, 32'h200);
        wr(2'd3, 32'h200);
        rd(2'd3, v); check("R9 later clear works", v, 32'h0);
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, v); check("R2 mask upper bits read zero", v, ALL_MASK);
        wr(2'd3, 32'hF000_0000);
        rd(2'd3, v); check("R2 pending upper bits read zero", v, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rise();
        t_fall_both();
        t_level();
        t_undefined();
        t_mask_ranges();
        t_w1c();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule